// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block turns a serial stereo PCM stream into parallel samples. The stream arrives on one data line and is framed by a left/right frame clock. Every channel has a fixed slot of 32 bit clocks. The sample word is packed against the end of its slot, so its least significant bit is on the last bit clock. The word length is either 20 or 18 bits, chosen by a format-select input. The bits that come before the word are padding, and the block ignores them.

The whole block runs on the bit clock and has a synchronous, active-high reset. A level change of the frame clock marks the first bit of a new slot. When a slot has run to its full length, the last word-length bits are taken as the sample. The sample is sign-extended to the output width and placed on that channel's data output. A one-cycle valid strobe for that channel goes with it.

Top module: `rjust_audio_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both data outputs are zero and both valid strobes are low.
- R2: A slot in which the frame clock is low carries the left channel and drives only the left outputs. A slot in which it is high carries the right channel and drives only the right outputs. The two valid strobes are never high together.
- R3: With `wlen_sel` = 0, the captured word is the final 20 bits of the slot. These are taken MSB first, and bit 0 is on the 32nd bit clock.
- R4: With `wlen_sel` = 1, the captured word is the final 18 bits of the slot, MSB first.
- R5: The 12 (20-bit) or 14 (18-bit) leading bits of a slot do not affect the captured sample.
- R6: The output carries the captured word sign-extended to 24 bits. The word's top bit is copied into every higher output bit.
- R7: A channel's valid strobe is high for exactly one cycle. That cycle is the one right after the rising bit-clock edge that samples the slot's 32nd bit.
- R8: If the frame clock changes level before a slot has reached 32 bit clocks, the partial sample is dropped. No strobe is produced, and counting starts again for the new slot.
- R9: `wlen_sel` is taken only on the first bit clock of a slot. Changing it during a slot does not change how that slot's word is read.
- R10: Between strobes, each data output keeps the last sample it was given.
- R11: If a slot runs longer than 32 bit clocks, it gives exactly one sample, taken at its 32nd bit. The extra bits are ignored.
- R12: After reset, nothing is captured until the first frame-clock level change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_clk | input | 1 | Frame clock: low marks the left slot, high marks the right slot |
| sdata | input | 1 | Serial data, MSB first, right-justified in the slot |
| wlen_sel | input | 1 | Word length: 0 gives 20 bits, 1 gives 18 bits |
| left_data | output | 24 | Last left sample, sign-extended |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample, sign-extended |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
Complete frames are sent in both word lengths. The sample values include negative and positive words, which shows whether sign extension and MSB-first ordering are correct. The same words are sent with padding of all zeros, all ones and random bits, to show that the leading bits of a slot are ignored. Slots that are cut short and slots that run too long show whether the block counts exactly 32 clocks. A word-length change in the middle of a slot and a slot before the first frame edge show whether format and slot start are latched at the correct moment.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;
   localparam int NUM_CH = 2;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } rjrx_chan_e;

   typedef enum logic {
      FMT_WIDE   = 1'b0,
      FMT_NARROW = 1'b1
   } rjrx_fmt_e;
endpackage

// File: rtl/rjrx_slot_timer.sv
module rjrx_slot_timer
   import rjrx_pkg::*;
#(
   parameter int SLOT_LEN = 32,
   parameter int CNT_W    = $clog2(SLOT_LEN)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       frame_clk,
   input  logic       wlen_sel,
   output logic       last_o,
   output rjrx_chan_e chan_o,
   output rjrx_fmt_e  fmt_o
);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SLOT_LEN - 1);

   logic             fc_prev;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   rjrx_chan_e       chan_q;
   rjrx_fmt_e        fmt_q;

   logic             edge_hit;
   logic [CNT_W-1:0] pos;
   logic             live;

   always_comb begin
      edge_hit = frame_clk ^ fc_prev;
      pos      = edge_hit ? '0 : cnt_q;
      live     = edge_hit | armed_q;
      last_o   = live && (pos == LAST_POS);
      chan_o   = chan_q;
      fmt_o    = fmt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fc_prev <= frame_clk;
         cnt_q   <= '0;
         armed_q <= 1'b0;
         chan_q  <= CH_LEFT;
         fmt_q   <= FMT_WIDE;
      end else begin
         fc_prev <= frame_clk;
         cnt_q   <= pos + CNT_W'(1);
         if (edge_hit) begin
            armed_q <= 1'b1;
            chan_q  <= rjrx_chan_e'(frame_clk);
            fmt_q   <= rjrx_fmt_e'(wlen_sel);
         end else if (last_o) begin
            armed_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rjrx_shifter.sv
module rjrx_shifter #(
   parameter int SH_W = 20
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sdata,
   output logic [SH_W-1:0] word_o
);
   logic [SH_W-2:0] sh_q;

   assign word_o = {sh_q, sdata};

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= word_o[SH_W-2:0];
   end
endmodule

// File: rtl/rjrx_word_align.sv
module rjrx_word_align
   import rjrx_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int WLEN_WIDE   = 20,
   parameter int WLEN_NARROW = 18,
   parameter int SH_W        = 20
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          capture,
   input  rjrx_chan_e                    chan,
   input  rjrx_fmt_e                     fmt,
   input  logic [SH_W-1:0]               word,
   output logic [NUM_CH-1:0][OUT_W-1:0]  data_o,
   output logic [NUM_CH-1:0]             valid_o
);
   logic [OUT_W-1:0] ext_wide;
   logic [OUT_W-1:0] ext_sel;

   assign ext_wide = OUT_W'($signed(word[WLEN_WIDE-1:0]));

   generate
      if (WLEN_WIDE == WLEN_NARROW) begin : g_single_len
         assign ext_sel = ext_wide;
      end else begin : g_dual_len
         logic [OUT_W-1:0] ext_narrow;
         assign ext_narrow = OUT_W'($signed(word[WLEN_NARROW-1:0]));
         assign ext_sel    = (fmt == FMT_NARROW) ? ext_narrow : ext_wide;
      end
   endgenerate

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic hit;
      assign hit = capture && (int'(chan) == ch);
      always_ff @(posedge clk) begin
         if (rst) begin
            valid_o[ch] <= 1'b0;
            data_o[ch]  <= '0;
         end else begin
            valid_o[ch] <= hit;
            if (hit) data_o[ch] <= ext_sel;
         end
      end
   end
endmodule

// File: rtl/rjust_audio_rx.sv
module rjust_audio_rx
   import rjrx_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int SLOT_LEN    = 32,
   parameter int WLEN_WIDE   = 20,
   parameter int WLEN_NARROW = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_clk,
   input  logic             sdata,
   input  logic             wlen_sel,
   output logic [OUT_W-1:0] left_data,
   output logic             left_valid,
   output logic [OUT_W-1:0] right_data,
   output logic             right_valid
);
   localparam int SH_W  = (WLEN_WIDE > WLEN_NARROW) ? WLEN_WIDE : WLEN_NARROW;
   localparam int CNT_W = $clog2(SLOT_LEN);

   if (SH_W < 2) begin : g_bad_wlen
      $error("word lengths must be at least 2 bits");
   end
   if (SLOT_LEN < SH_W) begin : g_bad_slot
      $error("slot shorter than the longest word");
   end
   if (OUT_W < SH_W) begin : g_bad_out
      $error("output narrower than the longest word");
   end
   if ((1 << CNT_W) != SLOT_LEN) begin : g_bad_pow2
      $error("slot length must be a power of two");
   end

   logic                         last_bit;
   rjrx_chan_e                   cur_chan;
   rjrx_fmt_e                    cur_fmt;
   logic [SH_W-1:0]              word;
   logic [NUM_CH-1:0][OUT_W-1:0] data_all;
   logic [NUM_CH-1:0]            valid_all;

   rjrx_slot_timer #(.SLOT_LEN(SLOT_LEN), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .frame_clk(frame_clk), .wlen_sel(wlen_sel),
      .last_o(last_bit), .chan_o(cur_chan), .fmt_o(cur_fmt)
   );

   rjrx_shifter #(.SH_W(SH_W)) u_shift (
      .clk(clk), .rst(rst), .sdata(sdata), .word_o(word)
   );

   rjrx_word_align #(
      .OUT_W(OUT_W), .WLEN_WIDE(WLEN_WIDE), .WLEN_NARROW(WLEN_NARROW), .SH_W(SH_W)
   ) u_align (
      .clk(clk), .rst(rst), .capture(last_bit), .chan(cur_chan), .fmt(cur_fmt),
      .word(word), .data_o(data_all), .valid_o(valid_all)
   );

   assign left_data   = data_all[CH_LEFT];
   assign right_data  = data_all[CH_RIGHT];
   assign left_valid  = valid_all[CH_LEFT];
   assign right_valid = valid_all[CH_RIGHT];
endmodule

// File: rtl/rjrx_checker.sv
module rjrx_checker #(
   parameter int OUT_W    = 24,
   parameter int SLOT_LEN = 32,
   parameter int SIGN_LO  = 19
) (
   input logic             clk,
   input logic             rst,
   input logic             frame_clk,
   input logic [OUT_W-1:0] left_data,
   input logic             left_valid,
   input logic [OUT_W-1:0] right_data,
   input logic             right_valid
);
   logic       fc_d;
   logic       seen;
   logic [7:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         fc_d <= frame_clk;
         seen <= 1'b0;
         run  <= '0;
      end else begin
         fc_d <= frame_clk;
         if (frame_clk != fc_d) begin
            seen <= 1'b1;
            run  <= 8'd1;
         end else if (run != 8'hFF) begin
            run <= run + 8'd1;
         end
      end
   end

   p_valid_excl_r2: assert property (@(posedge clk) disable iff (rst)
      !(left_valid && right_valid));

   p_one_cycle_l_r7: assert property (@(posedge clk) disable iff (rst)
      left_valid |=> !left_valid);
   p_one_cycle_r_r7: assert property (@(posedge clk) disable iff (rst)
      right_valid |=> !right_valid);

   p_full_slot_l_r8: assert property (@(posedge clk) disable iff (rst)
      left_valid |-> (seen && run == 8'(SLOT_LEN) && fc_d == 1'b0));
   p_full_slot_r_r8: assert property (@(posedge clk) disable iff (rst)
      right_valid |-> (seen && run == 8'(SLOT_LEN) && fc_d == 1'b1));

   p_hold_l_r10: assert property (@(posedge clk) disable iff (rst)
      !left_valid |-> $stable(left_data));
   p_hold_r_r10: assert property (@(posedge clk) disable iff (rst)
      !right_valid |-> $stable(right_data));

   p_sign_l_r6: assert property (@(posedge clk) disable iff (rst)
      (left_data[OUT_W-1:SIGN_LO] == '0) || (left_data[OUT_W-1:SIGN_LO] == '1));
   p_sign_r_r6: assert property (@(posedge clk) disable iff (rst)
      (right_data[OUT_W-1:SIGN_LO] == '0) || (right_data[OUT_W-1:SIGN_LO] == '1));
endmodule

bind rjust_audio_rx rjrx_checker #(
   .OUT_W(OUT_W), .SLOT_LEN(SLOT_LEN), .SIGN_LO(SH_W - 1)
) u_rjrx_chk (
   .clk(clk), .rst(rst), .frame_clk(frame_clk),
   .left_data(left_data), .left_valid(left_valid),
   .right_data(right_data), .right_valid(right_valid)
);

// File: tb/test_rjust_audio_rx.sv
`timescale 1ns/1ps
module test_rjust_audio_rx;
   logic clk = 1'b0, rst = 1'b1, fc = 1'b0, sd = 1'b0, fmt = 1'b0;
   logic [23:0] left_data, right_data;
   logic left_valid, right_valid;

   int checks = 0, fails = 0;
   int lv_cnt = 0, rv_cnt = 0;
   logic [23:0] last_l = '0, last_r = '0;
   string cur_req = "R1";
   bit cmp_on = 0;

   always #2.5 clk = ~clk;

   rjust_audio_rx i_rjust_audio_rx (
      .clk(clk), .rst(rst), .frame_clk(fc), .sdata(sd), .wlen_sel(fmt),
      .left_data(left_data), .left_valid(left_valid),
      .right_data(right_data), .right_valid(right_valid)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [23:0] sx(input logic [23:0] v, input int n);
      logic [23:0] r = v;
      for (int b = n; b < 24; b++) r[b] = v[n-1];
      return r;
   endfunction

   // behavioural reference model
   logic m_prev, m_on, m_ch, m_fmt;
   logic m_bits[$];
   logic e_lv = 0, e_rv = 0;
   logic [23:0] e_ld = '0, e_rd = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_prev = fc; m_on = 0; m_bits.delete();
         e_lv = 0; e_rv = 0; e_ld = '0; e_rd = '0;
      end else begin
         e_lv = 0; e_rv = 0;
         if (fc !== m_prev) begin
            m_on = 1; m_bits.delete(); m_ch = fc; m_fmt = fmt;
         end
         m_prev = fc;
         if (m_on) begin
            m_bits.push_back(sd);
            if (m_bits.size() == 32) begin
               int n;
               logic [23:0] v;
               n = m_fmt ? 18 : 20;
               v = '0;
               for (int i = 32 - n; i < 32; i++) v = {v[22:0], m_bits[i]};
               if (m_ch == 1'b0) begin e_lv = 1; e_ld = sx(v, n); end
               else              begin e_rv = 1; e_rd = sx(v, n); end
               m_on = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !rst)
         check(cur_req, {14'd0, left_valid, right_valid, left_data, right_data},
                        {14'd0, e_lv, e_rv, e_ld, e_rd});
      if (!rst) begin
         if (left_valid)  begin lv_cnt++; last_l = left_data;  end
         if (right_valid) begin rv_cnt++; last_r = right_data; end
      end
   end

   // pad: 0 zeros, 1 ones, 2 random; flip_at toggles fmt at that bit (-1 none)
   task automatic send_slot(input logic lvl, input int len, input logic [19:0] val,
                            input int n, input int pad, input int flip_at);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         fc = lvl;
         if (i == flip_at) fmt = ~fmt;
         if (i < 32 && (31 - i) < n) sd = val[31-i];
         else if (pad == 0) sd = 1'b0;
         else if (pad == 1) sd = 1'b1;
         else sd = 1'($urandom % 2);
      end
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk); @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int l0, r0;
      repeat (3) @(posedge clk);
      #1 check("R1", {left_valid, right_valid, left_data, right_data}, 64'd0);
      @(negedge clk); rst = 0;
      cmp_on = 1;
      @(posedge clk); #1
      check("R1", {left_valid, right_valid, left_data, right_data}, 64'd0);

      cur_req = "R12";
      send_slot(1'b0, 32, 20'hFFFFF, 20, 2, -1);
      settle();
      check("R12", lv_cnt + rv_cnt, 0);
      send_slot(1'b1, 32, 20'h0, 20, 2, -1);
      settle();

      cur_req = "R3";
      fmt = 0; l0 = lv_cnt; r0 = rv_cnt;
      send_slot(1'b0, 32, 20'hA5C3E, 20, 2, -1);
      send_slot(1'b1, 32, 20'h1F00F, 20, 2, -1);
      @(posedge clk); #1
      check("R7", {right_valid, left_valid}, 2'b10);
      @(posedge clk); #1
      check("R7", {right_valid, left_valid}, 2'b00);
      @(negedge clk);
      check("R3", last_l, 24'hFA5C3E);
      check("R2", last_r, 24'h01F00F);
      check("R2", {lv_cnt - l0, rv_cnt - r0}, {32'd1, 32'd1});

      cur_req = "R4";
      fmt = 1;
      send_slot(1'b0, 32, 20'h2ABCD, 18, 2, -1);
      send_slot(1'b1, 32, 20'h0F0F1, 18, 2, -1);
      settle();
      check("R4", last_l, 24'hFEABCD);
      check("R6", last_r, 24'h00F0F1);

      cur_req = "R5";
      fmt = 0;
      send_slot(1'b0, 32, 20'h00001, 20, 1, -1);
      send_slot(1'b1, 32, 20'h80000, 20, 0, -1);
      settle();
      check("R5", last_l, 24'h000001);
      check("R6", last_r, 24'hF80000);
      check("R10", left_data, 24'h000001);

      cur_req = "R8";
      l0 = lv_cnt; r0 = rv_cnt;
      send_slot(1'b0, 20, 20'hFFFFF, 20, 1, -1);
      send_slot(1'b1, 32, 20'h12345, 20, 2, -1);
      settle();
      check("R8", {lv_cnt - l0, rv_cnt - r0}, {32'd0, 32'd1});
      check("R8", left_data, 24'h000001);
      check("R8", right_data, 24'h012345);

      cur_req = "R9";
      fmt = 0;
      send_slot(1'b0, 32, 20'h7FFFE, 20, 2, 16);
      send_slot(1'b1, 32, 20'h3FFFF, 18, 2, -1);
      settle();
      check("R9", last_l, 24'h07FFFE);
      check("R9", last_r, 24'hFFFFFF);

      cur_req = "R11";
      l0 = lv_cnt;
      send_slot(1'b0, 40, 20'h00005, 18, 1, -1);
      send_slot(1'b1, 32, 20'h00003, 18, 2, -1);
      settle();
      check("R11", lv_cnt - l0, 1);
      check("R11", last_l, 24'h000005);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule